// File: doc/BRIEF.md
# Table-Driven Pulse Sequence Generator

This block produces one switching drive signal as a chain of back-to-back intervals. A small table holds one row for each state of the sequence, with at most 16 rows. Each row sets the output level for its interval and names the condition that ends it. The interval can end when the interval timer reaches the row's own constant or a compare value supplied live by a control loop. It can also end when the timer overflows, or on the rising edge of one of several external event inputs, such as a zero-cross detector or a current-threshold comparator.

When an interval ends, the machine loads the next row and restarts the timer. After a row flagged as last, or after the final table row, it returns to row 0. The table is written through a simple write port and can be changed while the sequence runs. A running interval always keeps the row contents it was loaded with, so rewriting the active row cannot cause a glitch. External inputs are asynchronous. They pass through a two-stage synchroniser and a rising-edge detector before use.

Top module: `pulse_seq_gen`

## Requirements
- R1: During reset, and on every clock edge that samples `enable` low, `drive_out` becomes 0 and `state_idx` becomes 0.
- R2: A row word `wr_data` has these fields: bit 22 is the output level; bits 21:20 are the end source (0 constant, 1 loop value, 2 timer overflow, 3 external event); bits 19:17 are the external event index; bit 16 is the last-row flag; bits 15:0 are the constant. On the first clock edge that samples `enable` high after it was low, row 0 is loaded: `state_idx` becomes 0 and `drive_out` takes row 0's level.
- R3: A row with end source constant and constant C lasts max(C,1) clock cycles.
- R4: A row with end source loop value ends in the first cycle in which the timer plus one is at least `loop_val`. With a steady `loop_val` of L, the row lasts max(L,1) cycles.
- R5: A row with end source overflow lasts 2^16 clock cycles.
- R6: A row with end source external ends on a rising edge of the selected bit of `ext_evt`. The output changes on the third clock edge that samples the input high. Other bits have no effect, and an input held high does not end a later interval.
- R7: After a row without the last flag, the next row is `state_idx`+1. After a row with the last flag, or after row 15, the next row is row 0. `drive_out` changes only when a new row is loaded.
- R8: A table write to the row that is running leaves the current interval's level and length unchanged. The new contents apply the next time that row is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the sequence; low holds it at row 0 with output low |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table row to write |
| wr_data | input | 23 | Row word (fields in R2) |
| loop_val | input | 16 | Compare value from the control loop |
| ext_evt | input | 8 | Asynchronous external event inputs |
| drive_out | output | 1 | Registered pulse sequence output |
| state_idx | output | 4 | Index of the row being executed |

## Verification
A fault in the row sequencing appears on `state_idx` at the very next clock edge after an interval ends. A fault in the timer or in the end-condition select shows up as an interval that is too short or too long. That error is visible on both `drive_out` and `state_idx` at the cycle where the interval should have ended. A row register that follows table writes mid-interval shows up as a change in the output level, or in the interval length, before the interval's expected end.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int CMP_W     = 16;
  localparam int EVT_IDX_W = 3;
  localparam int NUM_EVT   = 1 << EVT_IDX_W;

  typedef enum logic [1:0] {
    SRC_CONST = 2'd0,
    SRC_LOOP  = 2'd1,
    SRC_OVF   = 2'd2,
    SRC_EXT   = 2'd3
  } end_src_e;

  typedef struct packed {
    logic                 level;
    end_src_e             src;
    logic [EVT_IDX_W-1:0] evt;
    logic                 last;
    logic [CMP_W-1:0]     cmp;
  } row_t;

  localparam int ROW_W = $bits(row_t);
endpackage

// File: rtl/psg_evt_sync.sv
module psg_evt_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/psg_row_table.sv
module psg_row_table
  import psg_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  row_t          wdata,
  input  logic [AW-1:0] raddr,
  output row_t          rdata
);
  row_t mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/psg_interval_timer.sv
module psg_interval_timer
  import psg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  end_src_e             src,
  input  logic [CMP_W-1:0]     cmp,
  input  logic [EVT_IDX_W-1:0] evt,
  input  logic [CMP_W-1:0]     loop_val,
  input  logic [NUM_EVT-1:0]   evt_rise,
  output logic                 hit
);
  logic [CMP_W-1:0] timer;
  logic [CMP_W:0]   next_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) timer <= '0;
    else                timer <= timer + 1'b1;
  end

  assign next_cnt = {1'b0, timer} + 1'b1;

  always_comb begin
    unique case (src)
      SRC_CONST: hit = next_cnt >= {1'b0, cmp};
      SRC_LOOP:  hit = next_cnt >= {1'b0, loop_val};
      SRC_OVF:   hit = &timer;
      default:   hit = evt_rise[evt];
    endcase
  end

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (rst)
    restart |=> timer == '0);
endmodule

// File: rtl/pulse_seq_gen.sv
module pulse_seq_gen
  import psg_pkg::*;
#(
  parameter int ROWS = 16,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [ROW_W-1:0]   wr_data,
  input  logic [CMP_W-1:0]   loop_val,
  input  logic [NUM_EVT-1:0] ext_evt,
  output logic               drive_out,
  output logic [AW-1:0]      state_idx
);
  row_t               cur, fetched;
  logic               loaded, hit, take;
  logic [AW-1:0]      idx, nidx;
  logic [NUM_EVT-1:0] evt_rise;

  psg_evt_sync #(.N(NUM_EVT)) u_sync (
    .clk (clk), .rst (rst), .din (ext_evt), .rise (evt_rise)
  );

  psg_row_table #(.ROWS(ROWS)) u_table (
    .clk (clk), .we (wr_en), .waddr (wr_addr), .wdata (row_t'(wr_data)),
    .raddr (nidx), .rdata (fetched)
  );

  psg_interval_timer u_timer (
    .clk (clk), .rst (rst), .restart (take || !loaded),
    .src (cur.src), .cmp (cur.cmp), .evt (cur.evt),
    .loop_val (loop_val), .evt_rise (evt_rise), .hit (hit)
  );

  assign take = enable && (!loaded || hit);

  always_comb begin
    if (!loaded || cur.last || idx == AW'(ROWS - 1)) nidx = '0;
    else                                             nidx = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      loaded <= 1'b0;
      idx    <= '0;
      cur    <= '0;
    end else if (take) begin
      loaded <= 1'b1;
      idx    <= nidx;
      cur    <= fetched;
    end
  end

  assign drive_out = cur.level;
  assign state_idx = idx;

  p_disable_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !drive_out && state_idx == '0);

  p_step_next_r7: assert property (@(posedge clk) disable iff (rst)
    enable && loaded && hit && !cur.last && idx != AW'(ROWS - 1)
      |=> state_idx == $past(state_idx) + 1'b1);

  p_wrap_last_r7: assert property (@(posedge clk) disable iff (rst)
    enable && loaded && hit && cur.last |=> state_idx == '0);

  p_hold_row_r8: assert property (@(posedge clk) disable iff (rst)
    enable && loaded && !hit |=> $stable(drive_out) && $stable(cur));
endmodule

// File: tb/pulse_seq_gen_test.sv
module pulse_seq_gen_test;
  import psg_pkg::*;

  localparam int ROWS = 16;
  localparam int AW   = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               enable = 1'b0;
  logic               wr_en = 1'b0;
  logic [AW-1:0]      wr_addr = '0;
  logic [ROW_W-1:0]   wr_data = '0;
  logic [CMP_W-1:0]   loop_val = '0;
  logic [NUM_EVT-1:0] ext_evt = '0;
  logic               drive_out;
  logic [AW-1:0]      state_idx;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_on = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  pulse_seq_gen #(.ROWS(ROWS)) uut (
    .clk (clk), .rst (rst), .enable (enable), .wr_en (wr_en),
    .wr_addr (wr_addr), .wr_data (wr_data), .loop_val (loop_val),
    .ext_evt (ext_evt), .drive_out (drive_out), .state_idx (state_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] mk(input logic lv, input logic [1:0] src,
                                     input logic [2:0] ev, input logic last,
                                     input logic [15:0] c);
    return {lv, src, ev, last, c};
  endfunction

  // Cycle-level expectation built from the requirements.
  logic [22:0] tbl [16];
  logic        m_loaded;
  logic [3:0]  m_idx;
  logic [22:0] m_row;
  logic [15:0] m_t;
  logic [7:0]  s1, s2, s3;

  always @(posedge clk) begin
    logic       m_end;
    logic [3:0] n;
    case (m_row[21:20])
      2'd0:    m_end = ({1'b0, m_t} + 17'd1) >= {1'b0, m_row[15:0]};
      2'd1:    m_end = ({1'b0, m_t} + 17'd1) >= {1'b0, loop_val};
      2'd2:    m_end = (m_t == 16'hFFFF);
      default: m_end = s2[m_row[19:17]] & ~s3[m_row[19:17]];
    endcase
    if (rst) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= ext_evt; s2 <= s1; s3 <= s2;
    end
    if (wr_en) tbl[wr_addr] <= wr_data;
    if (rst || !enable) begin
      m_loaded <= 1'b0; m_idx <= '0; m_row <= '0; m_t <= '0;
    end else if (!m_loaded || m_end) begin
      n = (!m_loaded || m_row[16] || m_idx == 4'd15) ? 4'd0 : m_idx + 4'd1;
      m_loaded <= 1'b1; m_idx <= n; m_row <= tbl[n]; m_t <= '0;
    end else begin
      m_t <= m_t + 16'd1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk({phase, " drive"}, {31'd0, drive_out}, {31'd0, m_row[22]});
      chk({phase, " idx"}, {28'd0, state_idx}, {28'd0, m_idx});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [22:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input logic [3:0] row, output int cnt);
    cnt = 0;
    while (state_idx == row && cnt < 70000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic restart_seq();
    enable = 1'b0;
    @(negedge clk);
    chk("R1 off drive", {31'd0, drive_out}, 32'd0);
    chk("R1 off idx", {28'd0, state_idx}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'd24601));
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset drive", {31'd0, drive_out}, 32'd0);
    chk("R1 reset idx", {28'd0, state_idx}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;

    // R2 R3 R7: constant lengths, zero constant, wrap on last flag
    phase = "R3";
    wr(4'd0, mk(1'b1, 2'd0, 3'd0, 1'b0, 16'd5));
    wr(4'd1, mk(1'b0, 2'd0, 3'd0, 1'b0, 16'd0));
    wr(4'd2, mk(1'b1, 2'd0, 3'd0, 1'b1, 16'd1));
    for (int i = 3; i < 16; i++) wr(4'(i), mk(1'b0, 2'd0, 3'd0, 1'b1, 16'd3));
    enable = 1'b1;
    @(negedge clk);
    chk("R2 first row level", {31'd0, drive_out}, 32'd1);
    chk("R2 first row idx", {28'd0, state_idx}, 32'd0);
    measure(4'd0, c); chk("R3 const 5 length", c, 32'd5);
    measure(4'd1, c); chk("R3 const 0 length", c, 32'd1);
    measure(4'd2, c); chk("R3 const 1 length", c, 32'd1);
    chk("R7 wrap after last", {28'd0, state_idx}, 32'd0);

    // R5: overflow interval
    phase = "R5";
    restart_seq();
    wr(4'd0, mk(1'b1, 2'd2, 3'd0, 1'b0, 16'd0));
    wr(4'd1, mk(1'b0, 2'd0, 3'd0, 1'b1, 16'd7));
    enable = 1'b1;
    @(negedge clk);
    measure(4'd0, c); chk("R5 overflow length", c, 32'd65536);
    measure(4'd1, c); chk("R5 follow row length", c, 32'd7);

    // R6: external event, ignored inputs, held-high input
    phase = "R6";
    restart_seq();
    wr(4'd0, mk(1'b1, 2'd3, 3'd2, 1'b0, 16'd0));
    wr(4'd1, mk(1'b0, 2'd0, 3'd0, 1'b1, 16'd4));
    enable = 1'b1;
    repeat (10) @(negedge clk);
    ext_evt[5] = 1'b1;
    repeat (3) @(negedge clk);
    ext_evt[5] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 other input ignored idx", {28'd0, state_idx}, 32'd0);
    chk("R6 other input ignored drive", {31'd0, drive_out}, 32'd1);
    ext_evt[2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 no change before third edge", {28'd0, state_idx}, 32'd0);
    @(negedge clk);
    chk("R6 change on third edge", {28'd0, state_idx}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R6 held input no retrigger idx", {28'd0, state_idx}, 32'd0);
    chk("R6 held input no retrigger drive", {31'd0, drive_out}, 32'd1);
    ext_evt = '0;

    // R8: rewrite of the running row
    phase = "R8";
    restart_seq();
    wr(4'd0, mk(1'b1, 2'd0, 3'd0, 1'b0, 16'd20));
    wr(4'd1, mk(1'b0, 2'd0, 3'd0, 1'b1, 16'd3));
    enable = 1'b1;
    @(negedge clk);
    repeat (5) @(negedge clk);
    wr(4'd0, mk(1'b0, 2'd0, 3'd0, 1'b0, 16'd2));
    chk("R8 level kept after write", {31'd0, drive_out}, 32'd1);
    measure(4'd0, c); chk("R8 old length kept", c, 32'd14);
    measure(4'd1, c); chk("R8 next row length", c, 32'd3);
    chk("R8 new level applied", {31'd0, drive_out}, 32'd0);
    measure(4'd0, c); chk("R8 new length applied", c, 32'd2);

    // R4 R6 R7 R8 R1: random tables and stimulus against the model
    phase = "R4 R6 R7 R8 R1 random";
    restart_seq();
    for (int i = 0; i < 16; i++) begin
      logic [1:0] s;
      s = 2'($urandom % 3);
      if (s == 2'd2) s = 2'd3;
      wr(4'(i), mk(1'($urandom), s, 3'($urandom), ($urandom % 6) == 0, 16'($urandom % 13)));
    end
    enable = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      enable = 1'b1;
      if ($urandom % 8 == 0) loop_val = 16'($urandom % 13);
      if ($urandom % 4 == 0) ext_evt[$urandom % 8] ^= 1'b1;
      if ($urandom % 40 == 0) begin
        logic [1:0] s;
        s = 2'($urandom % 3);
        if (s == 2'd2) s = 2'd3;
        wr_en = 1'b1;
        wr_addr = 4'($urandom);
        wr_data = mk(1'($urandom), s, 3'($urandom), ($urandom % 6) == 0, 16'($urandom % 13));
      end
      if ($urandom % 200 == 0) enable = 1'b0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk_on = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule